// File: doc/BRIEF.md
# Single-Error-Correcting Codec for 16-Bit Words

This block protects a 16-bit data word with five check bits that are stored beside the data rather than mixed into it, giving a 21-bit stored word. On the write side it forms the five check bits from the outgoing data. On the read side it takes the read data and the stored check bits and recomputes parity from the data. It then forms a 5-bit syndrome and returns the data with any single faulty data bit inverted. It also reports which of four outcomes the syndrome signals.

Both paths are purely combinational and share one fixed assignment of data bits to parity trees. Every data bit feeds either two or three trees, no two data bits feed the same set of trees, and every tree has exactly eight data inputs. The surrounding memory, its sequencing and any logging of errors belong to the user of the block.

Top module: `hsec_codec`

## Requirements
- R1: Check bit i on `wr_check` is the XOR of the data bits whose column has bit i set. The columns, d0 to d15 with bit i standing for check bit i, are 03, 05, 09, 11, 0A, 12, 0C, 14, 0B, 13, 0D, 15, 0E, 16, 1A, 1C (hex).
- R2: Every column has two or three bits set, all sixteen columns differ, and each of the five check bits depends on exactly eight data bits.
- R3: `syndrome` equals `rd_check` XOR the parity that R1 gives for `rd_data`. When it is zero, `err_none` is 1 and `corrected_data` equals `rd_data`.
- R4: When `syndrome` has exactly one bit set, `err_check` is 1 and `corrected_data` equals `rd_data`.
- R5: When `syndrome` equals the column of data bit j, `err_data` is 1 and `corrected_data` is `rd_data` with only bit j inverted.
- R6: When `syndrome` is nonzero and matches neither a single check bit nor any column, `err_multi` is 1 and `corrected_data` equals `rd_data`.
- R7: Exactly one of `err_none`, `err_data`, `err_check`, `err_multi` is 1 for every input.
- R8: A single inverted bit at any of the 21 stored positions is always restored on `corrected_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | 16 | Data word to be stored |
| wr_check | output | 5 | Check bits to store with `wr_data` |
| rd_data | input | 16 | Data word as read back |
| rd_check | input | 5 | Check bits as read back |
| corrected_data | output | 16 | Read data after correction |
| syndrome | output | 5 | Stored check bits XOR recomputed parity |
| err_none | output | 1 | Word read without error |
| err_data | output | 1 | One data bit was wrong and has been inverted |
| err_check | output | 1 | One check bit was wrong; data passed unchanged |
| err_multi | output | 1 | Uncorrectable pattern; data passed unchanged |

## Verification
The block holds no state, so a wrong entry in the parity assignment or the syndrome decode shows at the ports on the same input. It appears as a wrong `wr_check` for any word that sets the affected data bit, or as a wrong bit or wrong flag on the read side. A column wired to the wrong trees is caught by a flip of that one data bit, which is then either not repaired or repaired at the wrong place. Every one of the 32 syndrome values and every single and double flip over the 21 positions is therefore driven, so each syndrome value and each flip position is tried at least once.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  parameter int DATA_W = 16;
  parameter int CHK_W  = 5;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    HSEC_NONE  = 2'd0,
    HSEC_DATA  = 2'd1,
    HSEC_CHECK = 2'd2,
    HSEC_MULTI = 2'd3
  } hsec_kind_e;

  // Tree membership of each data bit; bit i selects check bit i.
  // Eight columns of weight two and eight of weight three.
  function automatic logic [CHK_W-1:0] col_of(input int j);
    logic [CHK_W-1:0] c;
    case (j)
      0:  c = 5'h03;
      1:  c = 5'h05;
      2:  c = 5'h09;
      3:  c = 5'h11;
      4:  c = 5'h0A;
      5:  c = 5'h12;
      6:  c = 5'h0C;
      7:  c = 5'h14;
      8:  c = 5'h0B;
      9:  c = 5'h13;
      10: c = 5'h0D;
      11: c = 5'h15;
      12: c = 5'h0E;
      13: c = 5'h16;
      14: c = 5'h1A;
      15: c = 5'h1C;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Data bits feeding check bit r, gathered from the columns.
  function automatic logic [DATA_W-1:0] row_sel(input int r);
    logic [DATA_W-1:0] s;
    logic [CHK_W-1:0]  c;
    s = '0;
    for (int j = 0; j < DATA_W; j++) begin
      c    = col_of(j);
      s[j] = c[r];
    end
    return s;
  endfunction

endpackage

// File: rtl/hsec_parity_gen.sv
module hsec_parity_gen
  import hsec_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CHK_W-1:0]  parity_out
);

  for (genvar r = 0; r < CHK_W; r++) begin : g_tree
    localparam logic [DATA_W-1:0] SEL = row_sel(r);
    assign parity_out[r] = ^(data_in & SEL);
  end

endmodule

// File: rtl/hsec_syn_decode.sv
module hsec_syn_decode
  import hsec_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_in,
  output logic [DATA_W-1:0] flip_mask,
  output hsec_kind_e        kind
);

  logic single_hit;
  logic zero_syn;

  for (genvar j = 0; j < DATA_W; j++) begin : g_match
    localparam logic [CHK_W-1:0] COL = col_of(j);
    assign flip_mask[j] = (syn_in == COL);
  end

  assign zero_syn   = (syn_in == '0);
  assign single_hit = !zero_syn && ((syn_in & (syn_in - 1'b1)) == '0);

  always_comb begin
    if (zero_syn)        kind = HSEC_NONE;
    else if (single_hit) kind = HSEC_CHECK;
    else if (|flip_mask) kind = HSEC_DATA;
    else                 kind = HSEC_MULTI;
  end

  // At most one data bit may ever be chosen for inversion.
  always_comb begin
    if (!$isunknown(syn_in)) begin
      assert_flip_onehot0_R5: assert ($onehot0(flip_mask))
        else $error("decode selects more than one data bit");
      assert_single_not_data_R4: assert (!(single_hit && |flip_mask))
        else $error("weight-one syndrome matched a data column");
    end
  end

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec
  import hsec_pkg::*;
(
  input  logic [15:0] wr_data,
  output logic [4:0]  wr_check,
  input  logic [15:0] rd_data,
  input  logic [4:0]  rd_check,
  output logic [15:0] corrected_data,
  output logic [4:0]  syndrome,
  output logic        err_none,
  output logic        err_data,
  output logic        err_check,
  output logic        err_multi
);

  logic [CHK_W-1:0]  rd_parity;
  logic [DATA_W-1:0] flip_mask;
  hsec_kind_e        kind;

  hsec_parity_gen u_enc (
    .data_in    (wr_data),
    .parity_out (wr_check)
  );

  hsec_parity_gen u_chk (
    .data_in    (rd_data),
    .parity_out (rd_parity)
  );

  assign syndrome = rd_check ^ rd_parity;

  hsec_syn_decode u_dec (
    .syn_in    (syndrome),
    .flip_mask (flip_mask),
    .kind      (kind)
  );

  assign corrected_data = rd_data ^ flip_mask;
  assign err_none  = (kind == HSEC_NONE);
  assign err_data  = (kind == HSEC_DATA);
  assign err_check = (kind == HSEC_CHECK);
  assign err_multi = (kind == HSEC_MULTI);

  always_comb begin
    if (!$isunknown({rd_data, rd_check})) begin
      assert_one_flag_R7: assert ($onehot({err_none, err_data, err_check, err_multi}))
        else $error("outcome flags not one-hot");
      assert_clean_word_R3: assert (!(syndrome == '0) || (err_none && corrected_data == rd_data))
        else $error("zero syndrome altered data");
      assert_check_pass_R4: assert (!err_check || ($countones(syndrome) == 1 && corrected_data == rd_data))
        else $error("check-bit error changed data");
      assert_data_fix_R5: assert (!err_data || $countones(corrected_data ^ rd_data) == 1)
        else $error("data error did not invert exactly one bit");
      assert_multi_pass_R6: assert (!err_multi || (corrected_data == rd_data && $countones(syndrome) >= 2))
        else $error("multiple error changed data");
    end
  end

endmodule

// File: tb/sim_hsec_codec.sv
module sim_hsec_codec;

  logic clk;
  logic rst_n;
  logic [15:0] wr_data;
  logic [4:0]  wr_check;
  logic [15:0] rd_data;
  logic [4:0]  rd_check;
  logic [15:0] corrected_data;
  logic [4:0]  syndrome;
  logic        err_none, err_data, err_check, err_multi;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // Parity trees as data masks, one per check bit (from R1).
  logic [15:0] rows [5];
  initial begin
    rows[0] = 16'h0F0F;
    rows[1] = 16'h7331;
    rows[2] = 16'hBCC2;
    rows[3] = 16'hD554;
    rows[4] = 16'hEAA8;
  end

  hsec_codec u0 (
    .wr_data        (wr_data),
    .wr_check       (wr_check),
    .rd_data        (rd_data),
    .rd_check       (rd_check),
    .corrected_data (corrected_data),
    .syndrome       (syndrome),
    .err_none       (err_none),
    .err_data       (err_data),
    .err_check      (err_check),
    .err_multi      (err_multi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [4:0] ref_par(input logic [15:0] d);
    logic [4:0] p;
    for (int r = 0; r < 5; r++) p[r] = ^(d & rows[r]);
    return p;
  endfunction

  function automatic logic [4:0] ref_col(input int j);
    logic [4:0] c;
    for (int r = 0; r < 5; r++) c[r] = rows[r][j];
    return c;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive a read word and compare every read-side output with the model.
  task automatic apply_read(input logic [15:0] d, input logic [4:0] c, input string req);
    logic [4:0]  s;
    logic [15:0] exp_d;
    logic [3:0]  exp_f;
    int          hit;
    @(posedge clk);
    rd_data  = d;
    rd_check = c;
    s     = c ^ ref_par(d);
    exp_d = d;
    hit   = -1;
    for (int j = 0; j < 16; j++) if (ref_col(j) == s) hit = j;
    if (s == 5'd0)                exp_f = 4'b1000;
    else if ($countones(s) == 1)  exp_f = 4'b0010;
    else if (hit >= 0) begin
      exp_f = 4'b0100;
      exp_d[hit] = ~exp_d[hit];
    end
    else                          exp_f = 4'b0001;
    @(negedge clk);
    check("R3", "syndrome", {27'd0, syndrome}, {27'd0, s});
    check(req, "corrected_data", {16'd0, corrected_data}, {16'd0, exp_d});
    check("R7", "flags", {28'd0, err_none, err_data, err_check, err_multi}, {28'd0, exp_f});
  endtask

  task automatic apply_write(input logic [15:0] d);
    @(posedge clk);
    wr_data = d;
    @(negedge clk);
    check("R1", "wr_check", {27'd0, wr_check}, {27'd0, ref_par(d)});
  endtask

  initial begin
    rst_n    = 1'b0;
    wr_data  = '0;
    rd_data  = '0;
    rd_check = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state / idle inputs: all-zero word is clean.
    @(negedge clk);
    check("R3", "idle err_none", {31'd0, err_none}, 32'd1);
    check("R1", "idle wr_check", {27'd0, wr_check}, 32'd0);

    // R2: structure of the columns seen through the encoder.
    for (int j = 0; j < 16; j++) begin
      apply_write(16'd1 << j);
      check("R2", "column weight 2..3", (($countones(wr_check) >= 2) && ($countones(wr_check) <= 3)) ? 32'd1 : 32'd0, 32'd1);
      for (int k = 0; k < j; k++)
        check("R2", "distinct columns", (ref_col(k) != wr_check) ? 32'd1 : 32'd0, 32'd1);
    end
    for (int r = 0; r < 5; r++)
      check("R2", "tree fan-in", $countones(rows[r]), 32'd8);
    for (int j = 0; j < 16; j++) begin
      apply_write(16'd1 << j);
      check("R1", "column value", {27'd0, wr_check}, {27'd0, ref_col(j)});
    end

    // R1, R3, R4, R5, R8: clean word and every single flip on random data.
    for (int n = 0; n < 200; n++) begin
      logic [15:0] d;
      logic [4:0]  p;
      d = (n == 0) ? 16'h0000 : (n == 1) ? 16'hFFFF : 16'($urandom);
      apply_write(d);
      p = wr_check;
      apply_read(d, p, "R3");
      for (int b = 0; b < 21; b++) begin
        if (b < 16) begin
          apply_read(d ^ (16'd1 << b), p, "R5");
          check("R8", "restored data", {16'd0, corrected_data}, {16'd0, d});
        end else begin
          apply_read(d, p ^ (5'd1 << (b - 16)), "R4");
          check("R8", "restored data", {16'd0, corrected_data}, {16'd0, d});
        end
      end
    end

    // R6: every pair of flipped positions.
    for (int n = 0; n < 3; n++) begin
      logic [15:0] d;
      logic [4:0]  p;
      d = 16'($urandom);
      p = ref_par(d);
      for (int a = 0; a < 21; a++)
        for (int b = a + 1; b < 21; b++) begin
          logic [20:0] w;
          w = {p, d} ^ (21'd1 << a) ^ (21'd1 << b);
          apply_read(w[15:0], w[20:16], "R6");
          check("R6", "double flip not clean", {31'd0, err_none}, 32'd0);
        end
    end

    // All 32 syndrome values on several words.
    for (int n = 0; n < 8; n++) begin
      logic [15:0] d;
      d = 16'($urandom);
      for (int s = 0; s < 32; s++)
        apply_read(d, ref_par(d) ^ 5'(s), "R6");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule